// File: doc/BRIEF.md
# Host Port Tail Tag Stripper

This block sits on the byte stream that runs from a management processor into the switch fabric through the host port. When tagging is switched on, the processor ends every frame with one extra byte. That byte tells the switch which front ports must receive the frame, and which egress priority queue to use there. The block removes this trailing byte and moves the flag marking the end of the frame back onto the byte before it. It turns the byte into a port mask, a queue number and an error flag, which it presents on side-band outputs when the frame ends.

Both sides use a byte-wide valid/ready handshake with an end-of-frame marker. The block keeps one payload byte in a register. It releases that byte only when the next input byte is present, because only then is it known whether the held byte is the last payload byte. The side-band result is registered on the clock edge that accepts the final input byte. It stays unchanged until the first byte of the next frame is accepted. When tagging is switched off, frames pass through unchanged and the side-band reports no forced destination.

The enable must only change between frames. The reset input is asynchronous and active low. Inside the block it is released synchronously, two clock edges after the input rises.

Top module: `host_tag_strip`

## Requirements
- R1: With tagging enabled, every byte of a frame except the final one appears on the output, unchanged and in the same order, and the final (tag) byte never appears.
- R2: With tagging enabled, the output end-of-frame flag is set exactly on the byte that came just before the tag byte.
- R3: With tagging disabled, every input byte and its end-of-frame flag pass through unchanged. At frame end the mask is 0000, the queue is 0 and the error flag is 0.
- R4: A tag whose bits [3:0] are 0001, 0010, 0100 or 1000 gives a mask with only bit 0, 1, 2 or 3 set (ports 1 to 4 in that order).
- R5: A tag whose bits [3:0] are 1111 gives the mask 1111 (all four ports).
- R6: A tag whose bits [7:4] are 0000, 0001 or 0010 gives queue number 0, 1 or 2.
- R7: A tag whose bits [3:0] are any other value (0000 included), or whose bits [7:4] exceed 0010, sets the error flag and gives mask 0000 and queue 0.
- R8: The valid flag of the side-band result is set from the clock edge that accepts a frame's final input byte. Mask, queue and error hold steady while it is set. It clears when the first byte of the next frame is accepted.
- R9: With tagging enabled, a one-byte frame produces no output byte and reports error 1, mask 0000 and queue 0.
- R10: While the output is valid and not accepted, the output byte stays valid and unchanged. No byte is lost or duplicated under back-pressure on either side.
- R11: After reset, the output valid and the side-band valid are low and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tag_en | input | 1 | Enables tag removal and decoding; change only between frames |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts the input byte |
| s_data | input | DATA_W | Input byte |
| s_last | input | 1 | Input byte ends the frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | DATA_W | Output byte |
| m_last | output | 1 | Output byte ends the frame |
| info_valid | output | 1 | Side-band result of the last frame is valid |
| dest_mask | output | 4 | Forced destination ports, bit 0 = port 1 |
| dest_queue | output | 2 | Egress queue at the destination |
| tag_err | output | 1 | Tag was reserved, unlisted or missing payload |

## Verification
Directed frames cover each one-hot port code, the all-ports code with the highest queue, the reserved zero code, a two-bit port code and an out-of-range queue. Together these separate correct decoding from a decoder that only checks one nibble or accepts any non-zero map. A tag-only frame and frames with tagging disabled show whether the trailing byte is removed only when it should be. Random frames of 1 to 10 bytes with random gaps on the input and random back-pressure on the output expose off-by-one end-flag placement, lost or repeated bytes while stalled, and side-band values that change before the next frame begins.

// File: rtl/host_tag_pkg.sv
package host_tag_pkg;
  localparam int unsigned TAG_W     = 8;
  localparam int unsigned NIB_W     = TAG_W / 2;
  localparam int unsigned PORT_CNT  = NIB_W;
  localparam int unsigned QUEUE_CNT = 3;
  localparam int unsigned QUEUE_W   = $clog2(QUEUE_CNT);

  typedef struct packed {
    logic [PORT_CNT-1:0] mask;
    logic [QUEUE_W-1:0]  queue;
    logic                err;
  } tag_info_t;
endpackage

// File: rtl/host_tag_decode.sv
module host_tag_decode
  import host_tag_pkg::*;
(
  input  logic [TAG_W-1:0] tag_byte,
  input  logic             tag_alone,
  output tag_info_t        info
);
  logic [NIB_W-1:0] port_code;
  logic [NIB_W-1:0] queue_code;
  logic             port_ok;
  logic             queue_ok;
  logic             bad;

  always_comb begin
    port_code  = tag_byte[NIB_W-1:0];
    queue_code = tag_byte[TAG_W-1:NIB_W];
    // one port, or the all-ports code
    port_ok    = (port_code == '1) || ($countones(port_code) == 1);
    queue_ok   = (32'(queue_code) < QUEUE_CNT);
    bad        = tag_alone || !port_ok || !queue_ok;
    info.err   = bad;
    info.mask  = bad ? '0 : PORT_CNT'(port_code);
    info.queue = bad ? '0 : queue_code[QUEUE_W-1:0];
  end
endmodule

// File: rtl/host_tag_strip_stage.sv
module host_tag_strip_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic              end_fire,
  output logic              start_fire,
  output logic              tag_alone
);
  logic              hold_valid_q, hold_valid_d;
  logic [DATA_W-1:0] hold_data_q;
  logic              in_frame_q, in_frame_d;
  logic              s_fire;
  logic              hold_load;

  always_comb begin
    if (tag_en) begin
      m_valid = hold_valid_q && s_valid;
      m_data  = hold_data_q;
      s_ready = !hold_valid_q || m_ready;
    end else begin
      m_valid = s_valid;
      m_data  = s_data;
      s_ready = m_ready;
    end
    m_last       = s_last;
    s_fire       = s_valid && s_ready;
    hold_load    = tag_en && s_fire;
    hold_valid_d = hold_valid_q;
    if (hold_load) hold_valid_d = !s_last;
    in_frame_d   = in_frame_q;
    if (s_fire) in_frame_d = !s_last;
    end_fire     = s_fire && s_last;
    start_fire   = s_fire && !in_frame_q;
    tag_alone    = tag_en && !hold_valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid_q <= 1'b0;
      in_frame_q   <= 1'b0;
    end else begin
      hold_valid_q <= hold_valid_d;
      in_frame_q   <= in_frame_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_load) hold_data_q <= s_data;
  end

  // R9: a tag with no payload before it is dropped, nothing goes out
  a_r9_tag_alone_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en && s_fire && s_last && !hold_valid_q) |-> !m_valid);

  // R10: a stalled output byte stays put
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en && m_valid && !m_ready) |=> (!tag_en || (hold_valid_q && $stable(m_data))));

  // R2: once the end flag leaves, no payload byte is left behind
  a_r2_last_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en && m_valid && m_ready && m_last) |=> !hold_valid_q);
endmodule

// File: rtl/host_tag_info_reg.sv
module host_tag_info_reg
  import host_tag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tag_en,
  input  logic      end_fire,
  input  logic      start_fire,
  input  tag_info_t dec_info,
  output logic      info_valid,
  output tag_info_t info
);
  logic      valid_d;
  tag_info_t info_d;

  always_comb begin
    valid_d = info_valid;
    info_d  = info;
    if (end_fire) begin
      valid_d = 1'b1;
      info_d  = tag_en ? dec_info : '0;
    end else if (start_fire) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_valid <= 1'b0;
      info       <= '0;
    end else begin
      info_valid <= valid_d;
      info       <= info_d;
    end
  end

  // R8: result appears right after the final byte is taken
  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> info_valid);

  // R8: result frozen until the next frame starts
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (info_valid && !end_fire && !start_fire) |=> (info_valid && $stable(info)));

  // R7: an error never carries a destination
  a_r7_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (info_valid && info.err) |-> (info.mask == '0 && info.queue == '0));

  // R4, R5: the mask is empty, a single port or every port
  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    info_valid |-> (($countones(info.mask) <= 1) || (info.mask == '1)));

  // R6: queue number within range
  a_r6_queue_range: assert property (@(posedge clk) disable iff (!rst_n)
    info_valid |-> (32'(info.queue) < QUEUE_CNT));
endmodule

// File: rtl/host_tag_strip.sv
module host_tag_strip
  import host_tag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_tag_en,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  input  logic                s_last,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [DATA_W-1:0]   m_data,
  output logic                m_last,
  output logic                info_valid,
  output logic [PORT_CNT-1:0] dest_mask,
  output logic [QUEUE_W-1:0]  dest_queue,
  output logic                tag_err
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       end_fire;
  logic       start_fire;
  logic       tag_alone;
  tag_info_t  dec_info;
  tag_info_t  info;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  host_tag_strip_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tag_en    (cfg_tag_en),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .s_last    (s_last),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_last    (m_last),
    .end_fire  (end_fire),
    .start_fire(start_fire),
    .tag_alone (tag_alone)
  );

  host_tag_decode u_dec (
    .tag_byte (s_data[TAG_W-1:0]),
    .tag_alone(tag_alone),
    .info     (dec_info)
  );

  host_tag_info_reg u_info (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tag_en    (cfg_tag_en),
    .end_fire  (end_fire),
    .start_fire(start_fire),
    .dec_info  (dec_info),
    .info_valid(info_valid),
    .info      (info)
  );

  assign dest_mask  = info.mask;
  assign dest_queue = info.queue;
  assign tag_err    = info.err;

  // R11: nothing is offered downstream while in reset
  a_r11_quiet_reset: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> !info_valid);
endmodule

// File: tb/tb_host_tag_strip.sv
module tb_host_tag_strip;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_tag_en;
  logic       s_valid, s_ready, s_last;
  logic [7:0] s_data;
  logic       m_valid, m_ready, m_last;
  logic [7:0] m_data;
  logic       info_valid;
  logic [3:0] dest_mask;
  logic [1:0] dest_queue;
  logic       tag_err;

  always #5 clk = ~clk;

  host_tag_strip dut (
    .clk(clk), .rst_n(rst_n), .cfg_tag_en(cfg_tag_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .info_valid(info_valid), .dest_mask(dest_mask), .dest_queue(dest_queue),
    .tag_err(tag_err)
  );

  int         errs = 0;
  int         checks = 0;
  logic [7:0] exp_data[$];
  logic       exp_last[$];
  bit         fired = 0;
  bit         pend = 0;
  logic [3:0] p_mask;
  logic [1:0] p_queue;
  logic       p_err;
  string      p_req;
  bit         stall = 0;
  logic [7:0] stall_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected side-band result {mask, queue, err}
  function automatic logic [6:0] exp_info(input logic [7:0] tag, input bit en, input int len);
    logic [3:0] lo;
    logic [3:0] hi;
    bit         ok;
    lo = tag[3:0];
    hi = tag[7:4];
    if (!en) return 7'd0;
    ok = (len > 1) && (lo == 4'h1 || lo == 4'h2 || lo == 4'h4 || lo == 4'h8 || lo == 4'hF)
         && (hi <= 4'h2);
    if (!ok) return {4'd0, 2'd0, 1'b1};
    return {lo, hi[1:0], 1'b0};
  endfunction

  function automatic string req_of(input logic [7:0] tag, input bit en, input int len);
    logic [6:0] e;
    e = exp_info(tag, en, len);
    if (!en) return "R3";
    if (len == 1) return "R9";
    if (e[0]) return "R7";
    if (e[6:3] == 4'hF) return "R5";
    return "R4";
  endfunction

  task automatic check_pending();
    if (pend) begin
      chk(info_valid == 1'b1, "R8", "info_valid held", info_valid, 1);
      chk(dest_mask == p_mask, p_req, "dest_mask", dest_mask, p_mask);
      chk(dest_queue == p_queue, "R6", "dest_queue", dest_queue, p_queue);
      chk(tag_err == p_err, p_req, "tag_err", tag_err, p_err);
    end
  endtask

  task automatic run_frame(input int len, input logic [7:0] tag, input bit en,
                           input int vprob, input int rprob);
    logic [7:0] bytes [0:15];
    logic [6:0] e;
    int         ptr;
    for (int i = 0; i < len; i++) bytes[i] = 8'($urandom);
    bytes[len-1] = tag;
    if (en) begin
      for (int i = 0; i < len - 1; i++) begin
        exp_data.push_back(bytes[i]);
        exp_last.push_back(i == len - 2);
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        exp_data.push_back(bytes[i]);
        exp_last.push_back(i == len - 1);
      end
    end
    ptr = 0;
    @(negedge clk);
    cfg_tag_en = en;
    while (ptr < len || exp_data.size() != 0) begin
      check_pending();
      if (!s_valid || fired)
        s_valid = (ptr < len) && (($urandom % 100) < vprob);
      if (ptr < len) begin
        s_data = bytes[ptr];
        s_last = (ptr == len - 1);
      end
      m_ready = (($urandom % 100) < rprob);
      #1;
      if (stall) begin
        chk(m_valid == 1'b1, "R10", "valid kept while stalled", m_valid, 1);
        chk(m_data == stall_data, "R10", "data kept while stalled", m_data, stall_data);
      end
      stall = m_valid && !m_ready;
      stall_data = m_data;
      if (m_valid && m_ready) begin
        if (exp_data.size() == 0) begin
          chk(0, en ? ((len == 1) ? "R9" : "R1") : "R3", "unexpected output byte", m_data, 0);
        end else begin
          chk(m_data == exp_data[0], en ? "R1" : "R3", "output byte", m_data, exp_data[0]);
          chk(m_last == exp_last[0], en ? "R2" : "R3", "output last", m_last, exp_last[0]);
          void'(exp_data.pop_front());
          void'(exp_last.pop_front());
        end
      end
      fired = s_valid && s_ready;
      if (fired) begin
        if (ptr == 0) pend = 0;
        if (ptr == len - 1) begin
          e = exp_info(tag, en, len);
          p_mask = e[6:3];
          p_queue = e[2:1];
          p_err = e[0];
          p_req = req_of(tag, en, len);
          pend = 1;
        end
        ptr++;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
    fired = 0;
    stall = 0;
  endtask

  function automatic logic [7:0] rand_tag();
    logic [3:0] lo_set [0:4];
    lo_set[0] = 4'h1; lo_set[1] = 4'h2; lo_set[2] = 4'h4; lo_set[3] = 4'h8; lo_set[4] = 4'hF;
    if (($urandom % 100) < 15) return 8'($urandom);
    return {4'($urandom % 3), lo_set[$urandom % 5]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_tag_en = 1'b1;
    s_valid = 1'b0;
    s_data = '0;
    s_last = 1'b0;
    m_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(m_valid == 1'b0, "R11", "m_valid after reset", m_valid, 0);
    chk(info_valid == 1'b0, "R11", "info_valid after reset", info_valid, 0);
    chk(s_ready == 1'b1, "R11", "s_ready after reset", s_ready, 1);

    // directed corners
    run_frame(4, 8'h01, 1, 100, 100);   // R4 port 1, queue 0
    run_frame(3, 8'h12, 1, 100, 50);    // R4 port 2, R6 queue 1
    run_frame(5, 8'h24, 1, 70, 60);     // R4 port 3, queue 2
    run_frame(2, 8'h28, 1, 100, 100);   // R4 port 4, single payload byte
    run_frame(3, 8'h2F, 1, 100, 100);   // R5 all ports, queue 2
    run_frame(3, 8'h00, 1, 100, 100);   // R7 reserved code
    run_frame(3, 8'h03, 1, 100, 100);   // R7 two ports
    run_frame(3, 8'h31, 1, 100, 100);   // R7 queue out of range
    run_frame(1, 8'h01, 1, 100, 100);   // R9 tag only
    run_frame(4, 8'h05, 0, 100, 100);   // R3 pass-through
    run_frame(1, 8'h11, 0, 100, 100);   // R3 single byte
    run_frame(6, 8'h14, 1, 40, 30);     // R10 heavy back-pressure

    for (int f = 0; f < 200; f++)
      run_frame(1 + int'($urandom % 10), rand_tag(), (($urandom % 100) < 80),
                30 + int'($urandom % 71), 30 + int'($urandom % 71));

    repeat (3) begin
      @(negedge clk);
      check_pending();
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule